// File: doc/BRIEF.md
# Boot Overlay Start-Up Sequencer

After a power-on clear this block asserts an active-low overlay flag. The address decoder uses that flag to map the boot ROM over address zero, so the processor fetches its first instructions from ROM. The expected boot code is a one-byte no-op (00h) followed by a three-byte jump (C3h and a two-byte target). That makes four reads. The block counts qualified read accesses to the card and drops the overlay once the fourth read has been counted. The decoder then returns to its normal map, and execution carries on at the jump target.

The read-access input is a level that rises once per qualified read, meaning card select together with the read strobe and read status. It is brought into the system clock domain through a configurable synchronizer and counted on its rising edge. A read that is held high for many clocks therefore counts once. A strap input enables the overlay. With the strap open the flag never asserts, but reads are still counted. The count is fixed at four in use and is a parameter. Once the overlay is released it stays released until the next power-on clear.

Top module: `boot_overlay_seq`

## Requirements
- R1: While power-on clear is active, and right after it, with the strap closed (strap_en = 1), overlay_n is 0.
- R2: With the strap open (strap_en = 0), overlay_n is 1 in every cycle.
- R3: Each rising edge of rd_access advances the access count by exactly one, however many clocks rd_access stays high.
- R4: After fewer than RELEASE_COUNT (default 4) counted accesses, overlay_n stays 0 while the strap is closed.
- R5: The rising edge of the RELEASE_COUNT-th access, first sampled at clock edge j, drives overlay_n to 1 after edge j+SYNC_STAGES (default j+2), and not earlier.
- R6: After release, further accesses and strap changes leave overlay_n at 1 until the next power-on clear.
- R7: Accesses counted while the strap is open count toward release. The strap acts on overlay_n without a clock.
- R8: A power-on clear in the middle of a sequence resets the count to zero, and a full RELEASE_COUNT new accesses are needed to release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous assert |
| strap_en | input | 1 | Overlay enable strap, 1 = closed (overlay allowed) |
| rd_access | input | 1 | Qualified card read indicator, one rising edge per read |
| overlay_n | output | 1 | Boot overlay flag to the address decoder, active low |

## Verification
The first read is a long held-high access. If it were counted more than once, the release would come early. The next reads are short pulses one clock apart, and the fourth read is timed to the exact clock so the release latency is checked both ways. Extra reads and strap toggles after the release show that the overlay cannot come back. A run with the strap open shows that counting goes on while the flag is forced off. A clear in the middle of a sequence separates a counter that resets from one that keeps stale counts.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
   typedef enum logic {
      OVL_ARMED    = 1'b0,
      OVL_RELEASED = 1'b1
   } ovl_state_e;

   function automatic int cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction
endpackage

// File: rtl/bov_edge_detect.sv
module bov_edge_detect #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic sampled;
   logic prev_q;

   if (SYNC_STAGES < 0) begin : g_bad_stages
      $error("bov_edge_detect: SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign sampled = din;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= din;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end
      assign sampled = chain_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sampled;
   end

   assign rise = sampled & ~prev_q;

   AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R3
endmodule

// File: rtl/bov_access_counter.sv
module bov_access_counter
   import boot_ovl_pkg::*;
#(
   parameter int RELEASE_COUNT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic armed
);
   localparam int CNT_W = cnt_width(RELEASE_COUNT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_COUNT - 1);

   if (RELEASE_COUNT < 1) begin : g_bad_count
      $error("bov_access_counter: RELEASE_COUNT must be at least 1");
   end

   ovl_state_e       state_q;
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OVL_ARMED;
         count_q <= '0;
      end else if (state_q == OVL_ARMED && step) begin
         if (count_q == LAST) state_q <= OVL_RELEASED;
         else                 count_q <= count_q + CNT_W'(1);
      end
   end

   assign armed = (state_q == OVL_ARMED);

   AST_NO_STEP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count_q) && $stable(state_q)); // R3
   AST_RELEASE_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(armed) |-> $past(count_q) == LAST); // R5
   AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !armed); // R6
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> count_q <= LAST); // R4
endmodule

// File: rtl/boot_overlay_seq.sv
module boot_overlay_seq #(
   parameter int RELEASE_COUNT = 4,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic strap_en,
   input  logic rd_access,
   output logic overlay_n
);
   logic access_rise;
   logic armed;

   bov_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk   (clk),
      .rst_n (por_n),
      .din   (rd_access),
      .rise  (access_rise)
   );

   bov_access_counter #(.RELEASE_COUNT(RELEASE_COUNT)) cnt_i (
      .clk   (clk),
      .rst_n (por_n),
      .step  (access_rise),
      .armed (armed)
   );

   assign overlay_n = ~(armed & strap_en);

   AST_NO_REARM: assert property (@(posedge clk) disable iff (!por_n)
      $rose(overlay_n) && $stable(strap_en) |=> overlay_n); // R6
   AST_RELEASE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!por_n)
      $fell(armed) |-> $past(access_rise)); // R5
endmodule

// File: tb/boot_overlay_seq_tb_top.sv
module boot_overlay_seq_tb_top;
   localparam int REL  = 4;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic strap_en = 1'b1;
   logic rd_access = 1'b0;
   logic overlay_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   boot_overlay_seq #(.RELEASE_COUNT(REL), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .por_n(por_n), .strap_en(strap_en),
      .rd_access(rd_access), .overlay_n(overlay_n)
   );

   // Behavioural reference model: delay queue of samples, rise counting.
   bit m_q[$];
   bit m_prev;
   int m_count;
   bit m_released;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_q.delete();
         m_prev = 1'b0;
         m_count = 0;
         m_released = 1'b0;
      end else begin
         m_q.push_back(rd_access);
         if (m_q.size() > SYNC) begin
            bit y;
            y = m_q.pop_front();
            if (y && !m_prev && !m_released) begin
               m_count++;
               if (m_count >= REL) m_released = 1'b1;
            end
            m_prev = y;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         logic exp;
         exp = ~(!m_released && strap_en);
         checks++;
         if (overlay_n !== exp) begin
            errors++;
            $display("FAIL model R5 t=%0t actual=%b expected=%b", $time, overlay_n, exp);
         end
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic access(input int high);
      rd_access = 1'b1;
      step(high);
      rd_access = 1'b0;
      step(2);
   endtask

   task automatic por_pulse();
      por_n = 1'b0;
      step(2);
      por_n = 1'b1;
      step(1);
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      step(2);
      @(negedge clk); check("R1 reset", overlay_n, 1'b0);
      por_n = 1'b1;
      step(1);
      @(negedge clk); check("R1 after reset", overlay_n, 1'b0);
      step(0);
      // long first access must count once (R3)
      @(posedge clk); #1;
      access(8);
      access(1);
      access(1);
      step(4);
      @(negedge clk); check("R3 long access counted once", overlay_n, 1'b0);
      check("R4 three accesses keep overlay", overlay_n, 1'b0);
      // exact release latency (R5)
      @(posedge clk); #1;
      rd_access = 1'b1;
      @(negedge clk); check("R5 before sample", overlay_n, 1'b0);
      @(negedge clk); check("R5 edge j", overlay_n, 1'b0);
      @(negedge clk); check("R5 edge j+1", overlay_n, 1'b0);
      @(negedge clk); check("R5 edge j+2 release", overlay_n, 1'b1);
      @(posedge clk); #1;
      rd_access = 1'b0;
      step(2);
      // post-release (R6)
      access(1); access(3); access(1);
      strap_en = 1'b0; step(2);
      strap_en = 1'b1; step(2);
      @(negedge clk); check("R6 held after release", overlay_n, 1'b1);

      // strap open (R2, R7)
      @(posedge clk); #1;
      strap_en = 1'b0;
      por_pulse();
      @(negedge clk); check("R2 strap open after reset", overlay_n, 1'b1);
      @(posedge clk); #1;
      access(1); access(2);
      @(negedge clk); check("R2 strap open during count", overlay_n, 1'b1);
      #2 strap_en = 1'b1; #1;
      check("R7 strap closes without clock", overlay_n, 1'b0);
      @(posedge clk); #1;
      access(1);
      step(3);
      @(negedge clk); check("R7 three counted incl. strap open", overlay_n, 1'b0);
      @(posedge clk); #1;
      access(1);
      step(3);
      @(negedge clk); check("R7 release after open-strap counts", overlay_n, 1'b1);

      // clear mid sequence (R8)
      @(posedge clk); #1;
      por_pulse();
      access(1); access(1); access(1);
      por_pulse();
      access(1); access(1); access(1);
      step(3);
      @(negedge clk); check("R8 count restarted", overlay_n, 1'b0);
      @(posedge clk); #1;
      access(1);
      step(3);
      @(negedge clk); check("R8 release after fresh four", overlay_n, 1'b1);

      done = 1'b1;
      report();
   end
endmodule